// File: doc/BRIEF.md
# Flash sector write-protection controller

This block sits between the command decoder of a 32-sector serial flash and its array. It decides whether a program, sector-erase or bulk-erase request may proceed. Protection comes from two independent sources. The first is a protected range: a three-bit protect code, together with a top/bottom select bit, picks a run of sectors that grows from one end of the array. The second is a two-bit lock entry per sector: a write-lock bit and a lock-down bit, and the lock-down bit makes the entry sticky until the next power-on reset.

A status-register write-disable bit works together with an active-low write-protect pin. When both are in force, the status register is frozen and every write to it is discarded. The allow flag is combinational, so the decoder can gate the operation in the same cycle it presents the request. Both the status register and the lock entries can be read back.

Top module: `flash_wp_ctrl`

## Requirements
- R1: The target sector of a request is cmd_addr[20:16]. A program (cmd_kind 0) or sector erase (cmd_kind 1) is denied when the write-lock bit (lock entry bit 0) of that sector is 1.
- R2: A lock write (lk_we) replaces the addressed entry {lock-down, write-lock} = lk_wdata[1:0] from the next cycle, provided the entry's lock-down bit (bit 1) is 0. Once lock-down is 1, writes to that entry are ignored until reset, and entries of other sectors stay writable.
- R3: Status layout: protect code at bits [4:2], top/bottom at bit 5, write-disable at bit 7, and all other bits read 0. With top/bottom 0, a program or erase to sector s is denied for code 0 never, for codes 1..5 when s >= 32 - 2^(code-1), and for codes 6 and 7 always.
- R4: With top/bottom 1, the range mirrors to the low end. A program or erase to sector s is denied for codes 1..5 when s < 2^(code-1), for codes 6 and 7 always, and for code 0 never.
- R5: A bulk erase (cmd_kind 2) is allowed exactly when the protect code is 000. Lock entries do not affect it.
- R6: While write-disable is 1 and wp_n is 0, status writes are ignored and the status readback does not change.
- R7: While write-disable is 0 or wp_n is 1, a status write takes effect in the readback from the next cycle.
- R8: cmd_allow is combinational in the request cycle. It is 0 whenever cmd_valid is 0 or cmd_kind is 3.
- R9: Power-on reset (rst_n low) clears the status register and every lock entry to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| cmd_valid | input | 1 | Request strobe |
| cmd_kind | input | 2 | 0 program, 1 sector erase, 2 bulk erase, 3 reserved |
| cmd_addr | input | 24 | Request byte address |
| cmd_allow | output | 1 | Request may proceed |
| sr_we | input | 1 | Status register write strobe |
| sr_wdata | input | 8 | Status register write data |
| sr_rdata | output | 8 | Status register readback |
| wp_n | input | 1 | Write-protect pin, active low |
| lk_we | input | 1 | Lock entry write strobe |
| lk_sector | input | 5 | Sector of the lock write |
| lk_wdata | input | 2 | {lock-down, write-lock} to write |
| lk_rd_sector | input | 5 | Sector selected for lock readback |
| lk_rdata | output | 2 | {lock-down, write-lock} of the selected sector |

## Verification
Every cycle, the assertions check four things. A granted program or erase never targets a write-locked sector or a fully protected array. A granted bulk erase always has a zero protect code. A locked-down entry never changes. A frozen status register keeps its value through a write. The exact shape of each protected range cannot be shown by those properties. Only the bench's sweep shows it: all sixteen top/bottom and code combinations against all 32 sectors, plus the lock sequences. The same holds for the release of lock-down by reset and for status writes that take effect once the freeze is lifted.

// File: rtl/flash_wp_ctrl.sv
module flash_wp_ctrl #(
  parameter int SEC_BITS = 5,
  parameter int ADDR_W   = 24,
  parameter int SEC_LSB  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_kind,
  input  logic [ADDR_W-1:0]   cmd_addr,
  output logic                cmd_allow,
  input  logic                sr_we,
  input  logic [7:0]          sr_wdata,
  output logic [7:0]          sr_rdata,
  input  logic                wp_n,
  input  logic                lk_we,
  input  logic [SEC_BITS-1:0] lk_sector,
  input  logic [1:0]          lk_wdata,
  input  logic [SEC_BITS-1:0] lk_rd_sector,
  output logic [1:0]          lk_rdata
);
  localparam int NSEC = 1 << SEC_BITS;

  logic [2:0]          bp_q;
  logic                tb_q;
  logic                srwd_q;
  logic [1:0]          lk_q [NSEC];
  logic [SEC_BITS-1:0] sec;
  logic [SEC_BITS:0]   prot_cnt;
  logic                in_range;
  logic                frozen;

  assign frozen   = srwd_q & ~wp_n;
  assign sec      = cmd_addr[SEC_LSB +: SEC_BITS];
  assign sr_rdata = {srwd_q, 1'b0, tb_q, bp_q, 2'b00};
  assign lk_rdata = lk_q[lk_rd_sector];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bp_q   <= '0;
      tb_q   <= 1'b0;
      srwd_q <= 1'b0;
    end else if (sr_we && !frozen) begin
      srwd_q <= sr_wdata[7];
      tb_q   <= sr_wdata[5];
      bp_q   <= sr_wdata[4:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEC; i++) lk_q[i] <= 2'b00;
    end else if (lk_we && !lk_q[lk_sector][1]) begin
      lk_q[lk_sector] <= lk_wdata;
    end
  end

  always_comb begin
    if (bp_q == 3'd0)      prot_cnt = '0;
    else if (bp_q >= 3'd6) prot_cnt = (SEC_BITS+1)'(NSEC);
    else                   prot_cnt = (SEC_BITS+1)'(1) << (bp_q - 3'd1);
  end

  assign in_range = tb_q ? ({1'b0, sec} < prot_cnt)
                         : ({1'b0, sec} >= ((SEC_BITS+1)'(NSEC) - prot_cnt));

  always_comb begin
    cmd_allow = 1'b0;
    if (cmd_valid) begin
      case (cmd_kind)
        2'd0, 2'd1: cmd_allow = !in_range && !lk_q[sec][0];
        2'd2:       cmd_allow = (bp_q == 3'd0);
        default:    cmd_allow = 1'b0;
      endcase
    end
  end
endmodule

module flash_wp_ctrl_chk #(
  parameter int SEC_BITS = 5,
  parameter int ADDR_W   = 24,
  parameter int SEC_LSB  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic [1:0]          cmd_kind,
  input logic [ADDR_W-1:0]   cmd_addr,
  input logic                cmd_allow,
  input logic                sr_we,
  input logic [7:0]          sr_rdata,
  input logic                wp_n,
  input logic [1:0]          lk_q [1 << SEC_BITS]
);
  logic [SEC_BITS-1:0] c_sec;
  logic                c_prog;
  assign c_sec  = cmd_addr[SEC_LSB +: SEC_BITS];
  assign c_prog = cmd_valid && (cmd_kind == 2'd0 || cmd_kind == 2'd1);

  p_lock_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (c_prog && cmd_allow) |-> (lk_q[c_sec][0] == 1'b0));

  p_full_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_prog && cmd_allow) |-> (sr_rdata[4:3] != 2'b11));

  p_bulk_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd2 && cmd_allow) |-> (sr_rdata[4:2] == 3'd0));

  p_idle_deny_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid || cmd_kind == 2'd3) |-> !cmd_allow);

  p_frozen_sr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && sr_rdata[7] && !wp_n) |=> (sr_rdata == $past(sr_rdata)));

  for (genvar g = 0; g < (1 << SEC_BITS); g++) begin : g_sticky
    p_lockdown_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_q[g][1] |=> (lk_q[g] == $past(lk_q[g])));
  end
endmodule

bind flash_wp_ctrl flash_wp_ctrl_chk #(.SEC_BITS(SEC_BITS), .ADDR_W(ADDR_W), .SEC_LSB(SEC_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
  .cmd_addr(cmd_addr), .cmd_allow(cmd_allow), .sr_we(sr_we),
  .sr_rdata(sr_rdata), .wp_n(wp_n), .lk_q(lk_q));

// File: tb/flash_wp_ctrl_tb.sv
module flash_wp_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_kind = 2'd0;
  logic [23:0] cmd_addr = '0;
  logic        cmd_allow;
  logic        sr_we = 1'b0;
  logic [7:0]  sr_wdata = '0;
  logic [7:0]  sr_rdata;
  logic        wp_n = 1'b1;
  logic        lk_we = 1'b0;
  logic [4:0]  lk_sector = '0;
  logic [1:0]  lk_wdata = '0;
  logic [4:0]  lk_rd_sector = '0;
  logic [1:0]  lk_rdata;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_wp_ctrl u_dut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit exp_prot(input int tb, input int bp, input int s);
    int n;
    n = (bp == 0) ? 0 : (bp >= 6) ? 32 : (1 << (bp - 1));
    return tb ? (s < n) : (s >= 32 - n);
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr_sr(input logic [7:0] d);
    @(negedge clk); sr_we = 1'b1; sr_wdata = d;
    @(negedge clk); sr_we = 1'b0;
  endtask

  task automatic wr_lk(input int s, input logic [1:0] d);
    @(negedge clk); lk_we = 1'b1; lk_sector = 5'(s); lk_wdata = d;
    @(negedge clk); lk_we = 1'b0;
  endtask

  task automatic req(input int kind, input int s, output bit allow);
    cmd_valid = 1'b1; cmd_kind = 2'(kind);
    cmd_addr = {3'b000, 5'(s), 16'h5a3c};
    #1 allow = cmd_allow;
    cmd_valid = 1'b0;
  endtask

  task automatic rd_lk(input int s, output logic [1:0] v);
    lk_rd_sector = 5'(s);
    #1 v = lk_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [1:0] v;
    do_reset();
    @(negedge clk);
    chk(sr_rdata == 8'h00, "R9 status reset", sr_rdata, 0);
    for (int s = 0; s < 32; s++) begin
      rd_lk(s, v);
      chk(v == 2'b00, "R9 lock reset", v, 0);
    end

    // R8 idle and reserved kind
    #1 chk(cmd_allow == 1'b0, "R8 idle", cmd_allow, 0);
    req(3, 4, a); chk(a == 1'b0, "R8 reserved kind", a, 0);

    // R3 R4 R5 sweep
    for (int tb = 0; tb < 2; tb++) begin
      for (int bp = 0; bp < 8; bp++) begin
        wr_sr(8'((tb << 5) | (bp << 2)));
        chk(sr_rdata == 8'((tb << 5) | (bp << 2)), "R7 status write", sr_rdata, (tb << 5) | (bp << 2));
        for (int s = 0; s < 32; s++) begin
          for (int k = 0; k < 2; k++) begin
            req(k, s, a);
            chk(a == !exp_prot(tb, bp, s), tb ? "R4 lower range" : "R3 upper range", a, !exp_prot(tb, bp, s));
          end
          #1;
        end
        req(2, 0, a);
        chk(a == (bp == 0), "R5 bulk erase", a, bp == 0);
        @(negedge clk);
      end
    end

    // R1 R2 locks
    wr_sr(8'h00);
    wr_lk(7, 2'b01);
    rd_lk(7, v); chk(v == 2'b01, "R2 lock write", v, 1);
    req(0, 7, a); chk(a == 1'b0, "R1 locked program", a, 0);
    req(1, 7, a); chk(a == 1'b0, "R1 locked erase", a, 0);
    req(0, 8, a); chk(a == 1'b1, "R1 neighbour free", a, 1);
    req(2, 0, a); chk(a == 1'b1, "R5 bulk ignores locks", a, 1);
    wr_lk(7, 2'b00);
    rd_lk(7, v); chk(v == 2'b00, "R2 unlock free", v, 0);
    req(0, 7, a); chk(a == 1'b1, "R1 unlocked program", a, 1);
    wr_lk(7, 2'b11);
    wr_lk(7, 2'b00);
    rd_lk(7, v); chk(v == 2'b11, "R2 lockdown sticky", v, 3);
    req(1, 7, a); chk(a == 1'b0, "R1 lockdown denies", a, 0);
    wr_lk(9, 2'b10);
    wr_lk(9, 2'b01);
    rd_lk(9, v); chk(v == 2'b10, "R2 lockdown clear wl sticky", v, 2);
    req(0, 9, a); chk(a == 1'b1, "R1 lockdown only allows", a, 1);
    wr_lk(10, 2'b01);
    rd_lk(10, v); chk(v == 2'b01, "R2 other sector writable", v, 1);
    do_reset();
    @(negedge clk);
    rd_lk(7, v); chk(v == 2'b00, "R9 reset releases lockdown", v, 0);
    wr_lk(7, 2'b01);
    rd_lk(7, v); chk(v == 2'b01, "R2 writable after reset", v, 1);

    // R6 R7 freeze
    wp_n = 1'b0;
    wr_sr(8'h84);
    chk(sr_rdata == 8'h84, "R7 write with wd clear", sr_rdata, 8'h84);
    wr_sr(8'h00);
    chk(sr_rdata == 8'h84, "R6 frozen write ignored", sr_rdata, 8'h84);
    wr_sr(8'h3c);
    chk(sr_rdata == 8'h84, "R6 frozen tb bp", sr_rdata, 8'h84);
    req(0, 31, a); chk(a == 1'b0, "R3 frozen range active", a, 0);
    wp_n = 1'b1;
    wr_sr(8'h00);
    chk(sr_rdata == 8'h00, "R7 pin released", sr_rdata, 0);
    wr_sr(8'hff);
    chk(sr_rdata == 8'hbc, "R3 reserved bits read 0", sr_rdata, 8'hbc);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule